// File: doc/BRIEF.md
# Configuration Stream Loader with Verify Mode

This block takes a configuration bit stream and writes it into an internal configuration image RAM. Bytes arrive either one bit per clock on `din[0]` or as whole bytes on `din`. Every input is sampled, and every output changes, on the rising edge of `cfg_clk`. The mode pins are latched when a cycle starts. They choose serial or byte-wide entry. They also choose whether the loader drives a rising address to an external parallel memory that supplies the stream.

After power-up the loader holds `busy_n` low for a fixed number of clocks while it initialises. It then releases the line and waits. Pulling `start_n` low while the loader is idle starts a configuration cycle. The loader throws away every byte until it sees the fixed header byte. It then takes a parameterised number of payload bytes and returns to idle.

If `cmp_req_n` is low when the cycle starts, nothing is written. Each payload byte is instead compared with the stored word at the same position. The first difference drives the registered `mismatch_n` output low, and it stays low until the next cycle starts. Data, header matching and address stepping only take place on clocks where `sel_n` is low.

Top module: `cfg_stream_loader`

## Requirements
- R1: While `por_n` is low, `busy_n` is low, `mismatch_n` is high and `ext_addr` is 0. After `por_n` rises, `busy_n` stays low for INIT_CYCLES rising edges (default 4) and is high from that edge on.
- R2: While idle (`busy_n` high), `start_n` low at a rising edge starts a cycle. From that edge `busy_n` is low and `mismatch_n` is high, and `mode_sel` and `cmp_req_n` are latched for the whole cycle. With `start_n` high, the loader stays idle.
- R3: During a cycle, an edge with `sel_n` high is ignored. No data bit or byte is taken, and `ext_addr` does not move.
- R4: Mode values 0, 1, 2, 5, 6 and 7 are byte-wide. One byte is taken from `din` at each accepted edge, with `din[0]` as the least significant bit.
- R5: Mode values 3 and 4 are serial. Only `din[0]` is used. One bit is taken per accepted edge, least significant bit first, and eight bits form a byte.
- R6: Every byte taken before the first byte equal to PREAMBLE (default 8'hB7) is discarded. A serial stream starts with a null byte 8'h00 and a byte-wide stream may carry leading bytes. Bytes after the header are payload.
- R7: In a load cycle, payload byte i is written to image word i, for i = 0 to DEPTH-1 (default 16). `busy_n` goes high at the edge that completes byte DEPTH-1.
- R8: When `cmp_req_n` is low at the start edge, the cycle writes no word. The stored image is unchanged afterwards.
- R9: In a verify cycle, `mismatch_n` goes low at the edge that completes the first payload byte that differs from its stored word. It then stays low until the next start edge, including while idle.
- R10: In modes 1, 2 and 5, `ext_addr` is 0 after the start edge and increases by one at each accepted edge. In all other modes it stays 0.
- R11: `start_n` low while a cycle is running has no effect on the cycle.
- R12: After power-up, every image word holds 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock, rising edge active |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| start_n | input | 1 | Start request, active low, honoured only while idle |
| busy_n | output | 1 | Low during initialisation and during a cycle |
| sel_n | input | 1 | Selects the loader; data edges are ignored while high |
| mode_sel | input | 3 | Entry mode, latched at the start edge |
| cmp_req_n | input | 1 | Low at the start edge selects verify instead of load |
| din | input | 8 | Stream data; `din[0]` alone in serial modes |
| ext_addr | output | 17 | Address for an external parallel memory |
| mismatch_n | output | 1 | Registered sticky compare error, active low |

## Verification
The bench loads the image and verifies it with streams that differ in entry width, address generation, leading junk bytes and the position of the differing byte. A fresh all-zero image is verified to check the power-up contents.

A load followed by a matching verify, then a verify that differs at a middle byte, then a second matching verify, separates three faults: a write that happens during a verify, a compare against the wrong word, and an error flag that is not cleared at the next start.

Serial streams carry junk on `din[7:1]`, which exposes use of the wrong data lane. A `sel_n`-high stall with `start_n` low in the middle of a serial byte exposes bit slips and stray restarts. A difference in the final byte checks the edge where `mismatch_n` falls and `busy_n` rises together.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
   typedef enum logic [1:0] {
      CL_INIT,
      CL_IDLE,
      CL_HEAD,
      CL_BODY
   } cl_state_e;

   typedef struct packed {
      logic serial;
      logic addr_gen;
   } cl_mode_t;
endpackage

// File: rtl/cfgld_mode_decode.sv
module cfgld_mode_decode
   import cfgld_pkg::*;
#(
   parameter int MODE_W = 3,
   parameter logic [(1<<MODE_W)-1:0] SERIAL_SET = 8'b0001_1000,
   parameter logic [(1<<MODE_W)-1:0] ADDR_SET   = 8'b0010_0110
) (
   input  logic [MODE_W-1:0] mode_code,
   output cl_mode_t          mode_cfg
);
   // one bit per mode value in each set mask
   always_comb begin
      mode_cfg.serial   = SERIAL_SET[mode_code];
      mode_cfg.addr_gen = ADDR_SET[mode_code];
   end
endmodule

// File: rtl/cfgld_byte_assembler.sv
module cfgld_byte_assembler #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic              serial,
   input  logic [BYTE_W-1:0] din,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_dat
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   logic [BYTE_W-2:0] shreg;
   logic [CNT_W-1:0]  bit_cnt;

   // first bit received lands in bit 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else if (clr) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else if (take && serial) begin
         shreg   <= {din[0], shreg[BYTE_W-2:1]};
         bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
      end
   end

   always_comb begin
      if (serial) begin
         byte_vld = take && (bit_cnt == LAST_BIT);
         byte_dat = {din[0], shreg};
      end else begin
         byte_vld = take;
         byte_dat = din;
      end
   end
endmodule

// File: rtl/cfgld_addr_counter.sv
module cfgld_addr_counter #(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= '0;
      else if (clr)  addr <= '0;
      else if (step) addr <= addr + 1'b1;
   end
endmodule

// File: rtl/cfgld_image_ram.sv
module cfgld_image_ram #(
   parameter int DEPTH        = 16,
   parameter int WORD_W       = 8,
   parameter bit RESET_IMAGE  = 1'b1,
   localparam int PTR_W       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   if (RESET_IMAGE) begin : g_rst_image
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we) begin
            mem[ptr] <= wdata;
         end
      end
   end else begin : g_plain_image
      always_ff @(posedge clk) begin
         if (we) mem[ptr] <= wdata;
      end
   end

   assign rdata = mem[ptr];
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
   import cfgld_pkg::*;
#(
   parameter int               BYTE_W      = 8,
   parameter int               DEPTH       = 16,
   parameter int               EXT_AW      = 17,
   parameter int               MODE_W      = 3,
   parameter int               INIT_CYCLES = 4,
   parameter logic [BYTE_W-1:0] PREAMBLE   = 8'hB7
) (
   input  logic              cfg_clk,
   input  logic              por_n,
   input  logic              start_n,
   output logic              busy_n,
   input  logic              sel_n,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              cmp_req_n,
   input  logic [BYTE_W-1:0] din,
   output logic [EXT_AW-1:0] ext_addr,
   output logic              mismatch_n
);
   localparam int PTR_W  = $clog2(DEPTH);
   localparam int INIT_W = $clog2(INIT_CYCLES + 1);
   localparam logic [PTR_W-1:0]  LAST_PTR  = PTR_W'(DEPTH - 1);
   localparam logic [INIT_W-1:0] LAST_INIT = INIT_W'(INIT_CYCLES - 1);

   if (BYTE_W < 2) begin : g_bad_byte_w
      $error("cfg_stream_loader: BYTE_W must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("cfg_stream_loader: DEPTH must be at least 2");
   end
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("cfg_stream_loader: INIT_CYCLES must be at least 1");
   end
   if (MODE_W != 3) begin : g_bad_mode_w
      $error("cfg_stream_loader: mode set masks assume MODE_W of 3");
   end

   cl_state_e         state;
   logic [MODE_W-1:0] mode_q;
   logic              verify_q;
   logic [PTR_W-1:0]  wptr;
   logic [INIT_W-1:0] init_cnt;
   logic              mism_q;

   cl_mode_t          mcfg;
   logic              start_fire;
   logic              take;
   logic              byte_vld;
   logic [BYTE_W-1:0] byte_dat;
   logic [BYTE_W-1:0] ram_rd;
   logic              body_byte;
   logic              ram_we;
   logic              diff_hit;

   cfgld_mode_decode #(.MODE_W(MODE_W)) u_decode (
      .mode_code (mode_q),
      .mode_cfg  (mcfg)
   );

   assign start_fire = (state == CL_IDLE) && !start_n;
   assign take       = ((state == CL_HEAD) || (state == CL_BODY)) && !sel_n;

   cfgld_byte_assembler #(.BYTE_W(BYTE_W)) u_asm (
      .clk      (cfg_clk),
      .rst_n    (por_n),
      .clr      (start_fire),
      .take     (take),
      .serial   (mcfg.serial),
      .din      (din),
      .byte_vld (byte_vld),
      .byte_dat (byte_dat)
   );

   cfgld_addr_counter #(.ADDR_W(EXT_AW)) u_addr (
      .clk   (cfg_clk),
      .rst_n (por_n),
      .clr   (start_fire),
      .step  (take && mcfg.addr_gen),
      .addr  (ext_addr)
   );

   assign body_byte = (state == CL_BODY) && byte_vld;
   assign ram_we    = body_byte && !verify_q;
   assign diff_hit  = body_byte && verify_q && (ram_rd != byte_dat);

   cfgld_image_ram #(.DEPTH(DEPTH), .WORD_W(BYTE_W), .RESET_IMAGE(1'b1)) u_ram (
      .clk   (cfg_clk),
      .rst_n (por_n),
      .we    (ram_we),
      .ptr   (wptr),
      .wdata (byte_dat),
      .rdata (ram_rd)
   );

   always_ff @(posedge cfg_clk or negedge por_n) begin
      if (!por_n) begin
         state    <= CL_INIT;
         init_cnt <= '0;
         mode_q   <= '0;
         verify_q <= 1'b0;
         wptr     <= '0;
         mism_q   <= 1'b0;
      end else begin
         case (state)
            CL_INIT: begin
               init_cnt <= init_cnt + 1'b1;
               if (init_cnt == LAST_INIT) state <= CL_IDLE;
            end
            CL_IDLE: begin
               if (!start_n) begin
                  state    <= CL_HEAD;
                  mode_q   <= mode_sel;
                  verify_q <= !cmp_req_n;
                  wptr     <= '0;
                  mism_q   <= 1'b0;
               end
            end
            CL_HEAD: begin
               if (byte_vld && (byte_dat == PREAMBLE)) state <= CL_BODY;
            end
            CL_BODY: begin
               if (byte_vld) begin
                  if (diff_hit) mism_q <= 1'b1;
                  wptr <= wptr + 1'b1;
                  if (wptr == LAST_PTR) state <= CL_IDLE;
               end
            end
            default: state <= CL_INIT;
         endcase
      end
   end

   assign busy_n     = (state == CL_IDLE);
   assign mismatch_n = !mism_q;
endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk #(
   parameter int EXT_AW = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_n,
   input logic              sel_n,
   input logic              busy_n,
   input logic              mismatch_n,
   input logic              verify_q,
   input logic [EXT_AW-1:0] ext_addr
);
   // R2: an idle loader with no start request stays idle
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_n && start_n) |=> busy_n);

   // R9: the error flag holds until a start edge
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mismatch_n && !(busy_n && !start_n)) |=> !mismatch_n);

   // R8: the error can only appear in a verify cycle
   assert_err_in_verify_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mismatch_n) |-> $past(verify_q));

   // R3: a deselected edge leaves the address alone
   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_n && sel_n) |=> $stable(ext_addr));

   // R10: the address moves by at most one per edge inside a cycle
   assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |=> ((ext_addr == $past(ext_addr)) || (ext_addr == $past(ext_addr) + 1'b1)));
endmodule

bind cfg_stream_loader cfg_stream_loader_chk #(.EXT_AW(EXT_AW)) u_chk (
   .clk        (cfg_clk),
   .rst_n      (por_n),
   .start_n    (start_n),
   .sel_n      (sel_n),
   .busy_n     (busy_n),
   .mismatch_n (mismatch_n),
   .verify_q   (verify_q),
   .ext_addr   (ext_addr)
);

// File: tb/tb_cfg_stream_loader.sv
module tb_cfg_stream_loader;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam int INIT_CYC   = 4;
   localparam logic [7:0] PRE = 8'hB7;

   typedef struct packed {
      logic [8*16-1:0] tag;
      logic            cb;
      logic            busy;
      logic            ce;
      logic            err;
      logic            ca;
      logic [16:0]     addr;
   } exp_t;

   logic        clk;
   logic        por_n;
   logic        start_n;
   logic        sel_n;
   logic [2:0]  mode_sel;
   logic        cmp_req_n;
   logic [7:0]  din;
   logic        busy_n;
   logic        mismatch_n;
   logic [16:0] ext_addr;

   exp_t        q[$];
   int          n_chk  = 0;
   int          n_fail = 0;
   logic [7:0]  pay [DEPTH];
   logic [7:0]  img [DEPTH];

   cfg_stream_loader #(
      .BYTE_W(8), .DEPTH(DEPTH), .EXT_AW(17), .MODE_W(3),
      .INIT_CYCLES(INIT_CYC), .PREAMBLE(PRE)
   ) dut (
      .cfg_clk(clk), .por_n(por_n), .start_n(start_n), .busy_n(busy_n),
      .sel_n(sel_n), .mode_sel(mode_sel), .cmp_req_n(cmp_req_n), .din(din),
      .ext_addr(ext_addr), .mismatch_n(mismatch_n)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input logic [8*16-1:0] tg, input logic [31:0] act, input logic [31:0] ex);
      n_chk++;
      if (act !== ex) begin
         n_fail++;
         $display("FAIL %0s actual=%0h expected=%0h", tg, act, ex);
      end
   endtask

   // driver: called at a falling edge, sets inputs, queues what the next rising edge must produce
   task automatic drive(input logic st, input logic sl, input logic [7:0] dv, input logic [8*16-1:0] tg,
                        input logic cb, input logic eb, input logic ce, input logic ee,
                        input logic ca, input logic [16:0] ea);
      start_n = st;
      sel_n   = sl;
      din     = dv;
      q.push_back('{tag:tg, cb:cb, busy:eb, ce:ce, err:ee, ca:ca, addr:ea});
      @(negedge clk);
   endtask

   // monitor: pops one expectation per rising edge and compares at the ports
   initial forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() != 0) begin
         exp_t e;
         e = q.pop_front();
         if (e.cb) chk(e.tag, {31'b0, busy_n}, {31'b0, e.busy});
         if (e.ce) chk(e.tag, {31'b0, mismatch_n}, {31'b0, e.err});
         if (e.ca) chk(e.tag, {15'b0, ext_addr}, {15'b0, e.addr});
      end
   end

   task automatic config_cycle(input logic [2:0] md, input bit vfy, input bit junk, input logic [8*16-1:0] tg);
      bit          ser;
      bit          ag;
      logic [7:0]  bl[$];
      int          first_pay;
      logic [16:0] a;
      logic        e;
      ser = (md == 3'd3) || (md == 3'd4);
      ag  = (md == 3'd1) || (md == 3'd2) || (md == 3'd5);
      mode_sel  = md;
      cmp_req_n = !vfy;
      // R2: start edge; sel_n high so nothing is taken on it
      drive(1'b0, 1'b1, 8'hFF, "R2 start", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 17'd0);
      mode_sel  = ~md;
      cmp_req_n = vfy;
      if (ser) bl.push_back(8'h00);
      else if (junk) bl.push_back(8'h5A);
      bl.push_back(PRE);
      first_pay = bl.size();
      for (int i = 0; i < DEPTH; i++) bl.push_back(pay[i]);
      a = '0;
      e = 1'b1;
      for (int bi = 0; bi < bl.size(); bi++) begin
         for (int k = 0; k < (ser ? 8 : 1); k++) begin
            logic [7:0] dv;
            logic       bz;
            if (bi == first_pay && k == (ser ? 3 : 0)) begin
               // R3 R11: deselected edge with a start request in the middle of a cycle
               drive(1'b0, 1'b1, 8'hA5, "R3 R11 stall", 1'b1, 1'b0, 1'b1, e, 1'b1, a);
            end
            dv = ser ? {7'b1010101, bl[bi][k]} : bl[bi];
            if (ag) a = a + 1'b1;
            bz = 1'b0;
            if ((!ser || k == 7) && bi >= first_pay) begin
               int p;
               p = bi - first_pay;
               if (vfy) begin
                  if (bl[bi] != img[p]) e = 1'b0;
               end else begin
                  img[p] = bl[bi];
               end
               bz = (p == DEPTH - 1);
            end
            drive(1'b1, 1'b0, dv, tg, 1'b1, bz, 1'b1, e, 1'b1, a);
         end
      end
      // R7 R9 R10: idle afterwards, flag and address hold
      drive(1'b1, 1'b0, 8'h00, "R7 R9 R10 idle", 1'b1, 1'b1, 1'b1, e, 1'b1, a);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: all requirements actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      por_n     = 1'b0;
      start_n   = 1'b1;
      sel_n     = 1'b1;
      mode_sel  = 3'd0;
      cmp_req_n = 1'b1;
      din       = 8'h00;
      for (int i = 0; i < DEPTH; i++) img[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1: state while reset is held
      chk("R1 reset busy", {31'b0, busy_n}, 32'd0);
      chk("R1 reset err", {31'b0, mismatch_n}, 32'd1);
      chk("R1 reset addr", {15'b0, ext_addr}, 32'd0);
      por_n = 1'b1;
      for (int k = 1; k <= INIT_CYC + 2; k++) begin
         // R1: start_n held high; busy releases on edge INIT_CYC
         drive(1'b1, 1'b1, 8'h00, "R1 init", 1'b1, (k >= INIT_CYC), 1'b1, 1'b1, 1'b1, 17'd0);
      end

      // R12 R8: fresh image is all zeros, byte-wide verify with junk lead byte
      for (int i = 0; i < DEPTH; i++) pay[i] = 8'h00;
      config_cycle(3'd0, 1'b1, 1'b1, "R12 R6 vfy zero");

      // R4 R6 R7 R10: load byte-wide with address generation
      for (int i = 0; i < DEPTH; i++) pay[i] = 8'(i * 37 + 3);
      config_cycle(3'd1, 1'b0, 1'b1, "R4 R7 R10 load");
      config_cycle(3'd6, 1'b1, 1'b0, "R4 R8 vfy same");

      // R5 R9: serial verify that differs at a middle byte
      pay[5] = pay[5] ^ 8'h40;
      config_cycle(3'd3, 1'b1, 1'b0, "R5 R9 vfy diff");

      // R8 R9: the differing verify wrote nothing; flag clears at start
      pay[5] = pay[5] ^ 8'h40;
      config_cycle(3'd2, 1'b1, 1'b1, "R8 R9 vfy back");

      // R5 R6 R7: serial load of a new image, address stays 0
      pay[9] = 8'hC3;
      config_cycle(3'd4, 1'b0, 1'b0, "R5 R7 ser load");
      config_cycle(3'd5, 1'b1, 1'b0, "R5 R10 vfy new");

      // R9: difference only in the final byte
      pay[DEPTH-1] = ~pay[DEPTH-1];
      config_cycle(3'd7, 1'b1, 1'b1, "R9 vfy last");

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule